// File: doc/BRIEF.md
# Nonvolatile SRAM Recall Controller

This block sequences data movement between a small shadow nonvolatile array and a working SRAM array. Both arrays are held as register arrays inside the block. Two digital supply-status inputs drive it. One reports that the supply is under the reset threshold. The other reports that the supply is under the switch threshold.

A dip under the reset threshold latches a recall request. The recall starts by itself once the supply is back above the switch threshold. It runs as a clear of every SRAM word followed by a copy of the shadow array into the SRAM. A software store copies the SRAM into the shadow array one word per cycle. Store requests are refused while the supply is low.

The host sees an address, write data, a write enable, a combinational read-data output and a busy flag. While busy is high the host gets no service. After a recall ends, a write enable that is still held is ignored until the host drops it. This keeps a stale write from corrupting the freshly recalled contents.

Top module: `nv_recall_ctrl`

## Requirements
- R1: While `rst_n` is low, `busy` is 1, because a recall request is latched by reset. If both supply flags are low, the recall launches at the first clock edge after reset release.
- R2: A recall keeps `busy` high for exactly `RECALL_CYCLES` cycles, where `RECALL_CYCLES` is at least 2*DEPTH. It clears every SRAM word to zero and then copies the shadow array into the SRAM. Afterwards every SRAM word equals the shadow word at the same address.
- R3: Any cycle with `vlow_reset` = 1 latches a recall request. The request stays latched when `vlow_reset` falls, and `busy` stays 1. The recall launches only at an edge where both `vlow_reset` and `vlow_switch` are 0.
- R4: A `store_req` sampled while `vlow_switch` = 1 is dropped. The shadow array keeps its contents, which a later recall shows.
- R5: A `store_req` sampled while the block is idle, has no pending recall and has `vlow_switch` = 0 starts a store. The store holds `busy` high for DEPTH cycles and copies every SRAM word into the shadow array. A `store_req` that arrives while `busy` is high is ignored.
- R6: A recall request latched during a store waits. The store finishes, and the recall launches after it once the supply flags allow.
- R7: While `busy` is 1, `rdata` reads 0 and host writes are dropped.
- R8: When a recall launches, host writes are blocked. They stay blocked until an edge where the block is idle and `we` is sampled 0.
- R9: A recall never changes the shadow array. Back-to-back recalls give the same SRAM contents.
- R10: When idle, `rdata` shows the SRAM word at `addr` in the same cycle. A write of `wdata` at `addr` with `we` = 1 takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vlow_reset | input | 1 | Supply under reset threshold |
| vlow_switch | input | 1 | Supply under switch threshold |
| store_req | input | 1 | Request to copy SRAM into the shadow array |
| addr | input | AW | Host word address |
| wdata | input | DW | Host write data |
| we | input | 1 | Host write enable |
| rdata | output | DW | Host read data, 0 while busy |
| busy | output | 1 | Recall pending or running, or store running |

## Verification
A bad recall counter shows up at the ports as a `busy` pulse that is too long or too short. The error is caught on the first cycle it appears, because the bench compares `busy` every cycle. A bad clear, copy or store index leaves a wrong SRAM word. That word reads back wrongly as soon as the bench sweeps addresses after the next recall. A lost or cleared pending flag, or a stale write-block flag, shows at once as a `busy` or `rdata` mismatch against the reference model.

// File: rtl/nv_recall_ctrl.sv
module nv_recall_ctrl #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int RECALL_CYCLES = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vlow_reset,
  input  logic          vlow_switch,
  input  logic          store_req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] rdata,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(RECALL_CYCLES + DEPTH + 1);

  typedef enum logic [1:0] {IDLE, RECALL, STORE} state_t;

  state_t                     state;
  logic [CW-1:0]              cnt;
  logic                       pend;
  logic                       wr_block;
  logic [DEPTH-1:0][DW-1:0]   nv;
  logic [DW-1:0]              sram [DEPTH];

  logic [AW-1:0] idx;
  logic          launch, st_go, host_wr, in_recall, in_store;

  assign idx       = cnt[AW-1:0];
  assign in_recall = (state == RECALL);
  assign in_store  = (state == STORE);
  assign launch    = (state == IDLE) && pend && !vlow_switch && !vlow_reset;
  assign st_go     = (state == IDLE) && !pend && store_req && !vlow_switch;
  assign busy      = (state != IDLE) || pend;
  assign host_wr   = we && !busy && !wr_block;
  assign rdata     = busy ? '0 : sram[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      cnt      <= '0;
      pend     <= 1'b1;
      wr_block <= 1'b0;
      nv       <= '0;
    end else begin
      pend <= vlow_reset | (pend & !launch);
      case (state)
        IDLE: begin
          cnt <= '0;
          if (launch) begin
            state    <= RECALL;
            wr_block <= 1'b1;
          end else begin
            if (st_go) state <= STORE;
            if (!we) wr_block <= 1'b0;
          end
        end
        RECALL: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(RECALL_CYCLES - 1)) state <= IDLE;
        end
        STORE: begin
          nv[idx] <= sram[idx];
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DEPTH - 1)) state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (in_recall && cnt < CW'(2 * DEPTH))
      sram[idx] <= (cnt < CW'(DEPTH)) ? '0 : nv[idx];
    else if (host_wr)
      sram[addr] <= wdata;
  end
endmodule

module nv_recall_ctrl_chk #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int RECALL_CYCLES = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     vlow_reset,
  input logic                     vlow_switch,
  input logic                     store_req,
  input logic                     we,
  input logic                     busy,
  input logic [DW-1:0]            rdata,
  input logic                     in_recall,
  input logic                     in_store,
  input logic                     wr_block,
  input logic [(1<<AW)*DW-1:0]    nv_flat
);
  int len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) len <= 0;
    else if (in_recall) len <= len + 1;
    else len <= 0;

  initial a_r2_len_param: assert (RECALL_CYCLES >= 2 * (1 << AW));

  a_r2_recall_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_recall) |-> len == RECALL_CYCLES);
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    vlow_reset |=> busy);
  a_r3_no_launch_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_recall && (vlow_switch || vlow_reset)) |=> !in_recall);
  a_r4_store_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_store && vlow_switch) |=> !in_store);
  a_r7_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rdata == '0);
  a_r8_block_after: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_recall) |-> wr_block);
  a_r9_nv_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_recall |=> $stable(nv_flat));
endmodule

bind nv_recall_ctrl nv_recall_ctrl_chk #(.AW(AW), .DW(DW), .RECALL_CYCLES(RECALL_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .vlow_reset(vlow_reset), .vlow_switch(vlow_switch),
  .store_req(store_req), .we(we), .busy(busy), .rdata(rdata),
  .in_recall(in_recall), .in_store(in_store), .wr_block(wr_block), .nv_flat(nv)
);

// File: tb/nv_recall_ctrl_test.sv
`timescale 1ns/1ps
module nv_recall_ctrl_test;
  localparam int AW = 3, DW = 8, RC = 24;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, vrst = 0, vsw = 0, st = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic busy;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  nv_recall_ctrl #(.AW(AW), .DW(DW), .RECALL_CYCLES(RC)) uut (
    .clk(clk), .rst_n(rst_n), .vlow_reset(vrst), .vlow_switch(vsw),
    .store_req(st), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata), .busy(busy));

  always #10 clk = ~clk;

  int ms[DEPTH];
  int mn[DEPTH];
  int kind = 0, left = 0;
  bit pend = 1, hold = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend = 1; kind = 0; left = 0; hold = 0;
      foreach (mn[i]) mn[i] = 0;
    end else begin
      automatic bit was_pend = pend;
      automatic bit go = 0;
      if (kind != 0) begin
        left--;
        if (left == 0) begin
          if (kind == 1) foreach (ms[i]) ms[i] = mn[i];
          else foreach (mn[i]) mn[i] = ms[i];
          kind = 0;
        end
      end else if (was_pend) begin
        if (!vsw && !vrst) begin kind = 1; left = RC; hold = 1; pend = 0; go = 1; end
      end else begin
        if (we && !hold) ms[addr] = int'(wdata);
        if (st && !vsw) begin kind = 2; left = DEPTH; end
      end
      if (!go && (kind == 0 || left == DEPTH && kind == 2 && !was_pend) && !we && !(kind == 1)) ;
      if (vrst) pend = 1;
    end
  end

  // write-block release tracks idle edges with we low (separate for clarity)
  bit idle_pre;
  always @(negedge clk) idle_pre = (kind == 0);
  always @(posedge clk) if (rst_n && idle_pre && !we && kind != 1) #0 hold = 0;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    automatic bit mb = (kind != 0) || pend;
    check({cur_req, " busy"}, busy, mb);
    check({cur_req, " rdata"}, rdata, mb ? 0 : ms[addr]);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    addr = a[AW-1:0]; wdata = d[DW-1:0]; we = 1; tick(); we = 0; tick();
  endtask

  task automatic rd_all(string req, int vals[DEPTH]);
    for (int i = 0; i < DEPTH; i++) begin
      addr = i[AW-1:0]; #1;
      check(req, rdata, vals[i]);
      tick();
    end
  endtask

  task automatic dip();
    vsw = 1; vrst = 1; tick(2); vrst = 0; tick(3); vsw = 0;
    tick(RC + 3);
  endtask

  int snap[DEPTH], zero[DEPTH], pat[DEPTH];

  initial begin
    foreach (ms[i]) ms[i] = 0;
    foreach (mn[i]) mn[i] = 0;
    foreach (zero[i]) zero[i] = 0;
    tick(3);
    cur_req = "R1"; check("R1 busy in reset", busy, 1);
    rst_n = 1; tick();
    check("R1 busy after release", busy, 1);
    cur_req = "R2"; tick(RC - 2);
    check("R2 still busy", busy, 1);
    tick(2);
    check("R2 busy done", busy, 0);
    cur_req = "R9"; rd_all("R9 initial recall zero", zero);

    cur_req = "R10";
    for (int i = 0; i < DEPTH; i++) begin pat[i] = (i * 17 + 3) & 255; wr(i, pat[i]); end
    rd_all("R10 readback", pat);

    cur_req = "R5";
    st = 1; tick(); st = 0; tick(2);
    check("R5 busy in store", busy, 1);
    st = 1; tick(); st = 0;
    tick(DEPTH);
    check("R5 store done", busy, 0);

    cur_req = "R10";
    for (int i = 0; i < DEPTH; i++) wr(i, 8'hFF);
    cur_req = "R3";
    vsw = 1; vrst = 1; tick(); vrst = 0; tick(4);
    check("R3 request held", busy, 1);
    cur_req = "R7";
    addr = 0; wdata = 8'h11; we = 1; tick(); we = 0; tick();
    check("R7 read zero busy", rdata, 0);
    cur_req = "R3"; vsw = 0; tick(RC + 3);
    cur_req = "R2"; rd_all("R2 recall restores store", pat);

    cur_req = "R4";
    for (int i = 0; i < DEPTH; i++) wr(i, 8'hA0 + i);
    vsw = 1; st = 1; tick(); st = 0; tick(); vsw = 0; tick();
    dip();
    rd_all("R4 gated store left shadow", pat);

    cur_req = "R8";
    addr = 1; wdata = 8'h55;
    vsw = 1; vrst = 1; tick(); vrst = 0; vsw = 0;
    we = 1; tick(RC + 4);
    check("R8 held write dropped", rdata, pat[1]);
    we = 0; tick();
    wr(1, 8'h66);
    addr = 1; #1; check("R8 write after release", rdata, 8'h66);

    cur_req = "R6";
    for (int i = 0; i < DEPTH; i++) begin snap[i] = (i * 29 + 7) & 255; wr(i, snap[i]); end
    st = 1; tick(); st = 0; tick(2);
    vsw = 1; vrst = 1; tick(); vrst = 0; vsw = 0;
    tick(DEPTH - 3);
    check("R6 busy through queue", busy, 1);
    tick(RC + 4);
    rd_all("R6 queued recall sees store", snap);

    cur_req = "R9";
    dip(); rd_all("R9 recall one", snap);
    dip(); rd_all("R9 recall two", snap);

    tick(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule